// File: doc/BRIEF.md
# Transmit Byte Queue with Free-Space Interrupt

This block holds bytes on their way from a host to a UART serializer. The host writes a byte with a one-cycle strobe. The serializer takes the byte at the head of the queue with its own strobe whenever it can start a new character. A single input sets the capacity to either the full depth or half of it. Changing that input discards everything in the queue.

The interrupt request is based on free space, not on occupancy. A 2-bit level code picks one of four free-space thresholds, each one scaled to the current capacity. The thresholds are not listed in increasing order: code 01 asks for half the capacity free and code 10 asks for three quarters free. The reset code 00 asks for the queue to be completely empty. With that code the request drops as soon as one byte is written. The request only appears while the transmitter enable is high.

Top module: `tx_fifo_lvl_irq`

## Requirements
- R1: After reset the queue is empty at the shallow capacity: `free_o` = 8, `empty_o` = 1, `ready_o` = 1 and `ovf_o` = 0. With code 00, `irq_o` follows `tx_en_i`.
- R2: `deep_i` = 0 gives a capacity of 8 bytes and `deep_i` = 1 gives 16 bytes. `free_o` equals the capacity minus the number of bytes stored.
- R3: Bytes leave in the order they were written. `rd_data_o` always shows the oldest stored byte, and a pop advances to the next one.
- R4: At capacity 8 the interrupt condition is: code 01, free ≥ 4; code 10, free ≥ 6; code 11, free ≥ 1; code 00, free = 8.
- R5: At capacity 16 the interrupt condition is: code 01, free ≥ 8; code 10, free ≥ 12; code 11, free ≥ 1; code 00, free = 16.
- R6: `irq_o` is the interrupt condition ANDed with `tx_en_i`. With code 00, writing one byte into the empty queue drops `irq_o` in the next cycle.
- R7: A write while the queue is full stores nothing and raises `ovf_o` for the one cycle after that write.
- R8: A pop while the queue is empty has no effect: the free count stays at the capacity.
- R9: A write and a pop in the same cycle on a queue that is neither empty nor full leave `free_o` unchanged and keep the byte order. On a full queue, the pop is taken and the write is dropped with `ovf_o`.
- R10: A change of `deep_i` empties the queue on the next clock edge. Writes and pops in the cycle of the change are discarded.
- R11: `empty_o` is high exactly when `free_o` equals the capacity. `ready_o` is high exactly when `free_o` is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| deep_i | input | 1 | Capacity select: 0 = half depth, 1 = full depth |
| lvl_code_i | input | 2 | Free-space threshold code |
| tx_en_i | input | 1 | Transmitter enable, gates the interrupt |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Byte to write |
| rd_en_i | input | 1 | Serializer pop strobe |
| rd_data_o | output | 8 | Oldest stored byte |
| free_o | output | 5 | Number of free positions |
| empty_o | output | 1 | Queue empty |
| ready_o | output | 1 | At least one position free |
| irq_o | output | 1 | Transmit interrupt request |
| ovf_o | output | 1 | Write-overflow pulse |

## Verification
The host write and the serializer pop can fall in the same cycle. The bench drives both strobes together on a partly filled queue, then checks that the free count does not move and that the following pops return the bytes in order. It then repeats the collision on a full queue. In that case the free count must rise by one, the overflow pulse must appear, and the dropped byte must never come out of the queue.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  typedef enum logic [1:0] {
    LVL_EMPTY = 2'b00,
    LVL_HALF  = 2'b01,
    LVL_3Q    = 2'b10,
    LVL_ANY   = 2'b11
  } lvl_code_e;
endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store #(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 16,
  parameter int PTR_W     = $clog2(MAX_DEPTH),
  parameter int CNT_W     = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [CNT_W-1:0]  cap_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] mem_q [MAX_DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q, wptr_nx, rptr_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign do_push = push_i & (cnt_q < cap_i) & ~clr_i;
  assign do_pop  = pop_i & (cnt_q != '0) & ~clr_i;

  // pointers wrap at the selected capacity, not at MAX_DEPTH
  assign wptr_nx = ({1'b0, wptr_q} == cap_i - 1'b1) ? '0 : wptr_q + 1'b1;
  assign rptr_nx = ({1'b0, rptr_q} == cap_i - 1'b1) ? '0 : rptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_nx;
      if (do_pop)  rptr_q <= rptr_nx;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/tx_fifo_thresh.sv
module tx_fifo_thresh
  import tx_fifo_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] cap_i,
  input  logic [CNT_W-1:0] free_i,
  input  lvl_code_e        code_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] half_lvl, tq_lvl;

  assign half_lvl = cap_i >> 1;
  assign tq_lvl   = cap_i - (cap_i >> 2);

  always_comb begin
    unique case (code_i)
      LVL_EMPTY: hit_o = (free_i == cap_i);
      LVL_HALF:  hit_o = (free_i >= half_lvl);
      LVL_3Q:    hit_o = (free_i >= tq_lvl);
      default:   hit_o = (free_i != '0);
    endcase
  end
endmodule

// File: rtl/tx_fifo_lvl_irq.sv
module tx_fifo_lvl_irq
  import tx_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 16,
  parameter int PTR_W     = $clog2(MAX_DEPTH),
  parameter int CNT_W     = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              deep_i,
  input  logic [1:0]        lvl_code_i,
  input  logic              tx_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  free_o,
  output logic              empty_o,
  output logic              ready_o,
  output logic              irq_o,
  output logic              ovf_o
);
  localparam logic [CNT_W-1:0] CAP_DEEP    = CNT_W'(MAX_DEPTH);
  localparam logic [CNT_W-1:0] CAP_SHALLOW = CNT_W'(MAX_DEPTH / 2);

  logic             deep_q, depth_chg, ovf_q, hit;
  logic [CNT_W-1:0] cap, cnt;

  assign depth_chg = deep_i ^ deep_q;
  assign cap       = deep_q ? CAP_DEEP : CAP_SHALLOW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deep_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      deep_q <= deep_i;
      ovf_q  <= wr_en_i & (cnt == cap) & ~depth_chg;
    end
  end

  tx_fifo_store #(
    .DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (depth_chg),
    .cap_i   (cap),
    .push_i  (wr_en_i),
    .pop_i   (rd_en_i),
    .wdata_i (wr_data_i),
    .rdata_o (rd_data_o),
    .cnt_o   (cnt)
  );

  assign free_o  = cap - cnt;
  assign empty_o = (cnt == '0);
  assign ready_o = (cnt != cap);

  tx_fifo_thresh #(.CNT_W(CNT_W)) u_thresh (
    .cap_i  (cap),
    .free_i (free_o),
    .code_i (lvl_code_e'(lvl_code_i)),
    .hit_o  (hit)
  );

  assign irq_o = hit & tx_en_i;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tx_fifo_lvl_irq_chk.sv
module tx_fifo_lvl_irq_chk #(
  parameter int MAX_DEPTH = 16,
  parameter int CNT_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_en_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [CNT_W-1:0] free_o,
  input logic             empty_o,
  input logic             ready_o,
  input logic             irq_o,
  input logic             ovf_o,
  input logic             depth_chg
);
  // R7
  ovf_on_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !ready_o && !depth_chg |=> ovf_o);
  // R7
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !ovf_o);
  // R8
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !wr_en_i && empty_o && !depth_chg |=> empty_o);
  // R6
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> tx_en_i);
  // R10
  depth_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_chg |=> empty_o);
  // R9
  both_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && rd_en_i && !empty_o && ready_o && !depth_chg |=> free_o == $past(free_o));
  // R2
  free_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o <= CNT_W'(MAX_DEPTH));
endmodule

bind tx_fifo_lvl_irq tx_fifo_lvl_irq_chk #(.MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en_i   (tx_en_i),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .free_o    (free_o),
  .empty_o   (empty_o),
  .ready_o   (ready_o),
  .irq_o     (irq_o),
  .ovf_o     (ovf_o),
  .depth_chg (depth_chg)
);

// File: tb/tx_fifo_lvl_irq_tb.sv
`timescale 1ns/1ps
module tx_fifo_lvl_irq_tb;
  logic       clk_i = 0, rst_ni = 0, deep_i = 0, tx_en_i = 0;
  logic       wr_en_i = 0, rd_en_i = 0;
  logic [1:0] lvl_code_i = 2'b00;
  logic [7:0] wr_data_i = '0, rd_data_o;
  logic [4:0] free_o;
  logic       empty_o, ready_o, irq_o, ovf_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tx_fifo_lvl_irq u_dut (.*);

  // {deep, code, bytes stored, expected irq}
  localparam logic [8:0] VEC [16] = '{
    {1'b0, 2'b00, 5'd0,  1'b1}, {1'b0, 2'b00, 5'd1,  1'b0},
    {1'b0, 2'b01, 5'd4,  1'b1}, {1'b0, 2'b01, 5'd5,  1'b0},
    {1'b0, 2'b10, 5'd2,  1'b1}, {1'b0, 2'b10, 5'd3,  1'b0},
    {1'b0, 2'b11, 5'd7,  1'b1}, {1'b0, 2'b11, 5'd8,  1'b0},
    {1'b1, 2'b00, 5'd0,  1'b1}, {1'b1, 2'b00, 5'd1,  1'b0},
    {1'b1, 2'b01, 5'd8,  1'b1}, {1'b1, 2'b01, 5'd9,  1'b0},
    {1'b1, 2'b10, 5'd4,  1'b1}, {1'b1, 2'b10, 5'd5,  1'b0},
    {1'b1, 2'b11, 5'd15, 1'b1}, {1'b1, 2'b11, 5'd16, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk_i); wr_en_i = 1; wr_data_i = b;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string req);
    @(negedge clk_i);
    chk(rd_data_o == exp, req, rd_data_o, exp);
    rd_en_i = 1;
    @(negedge clk_i); rd_en_i = 0;
  endtask

  task automatic set_empty(input logic d);
    @(negedge clk_i); deep_i = ~d;
    @(negedge clk_i); deep_i = d;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #22 rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(free_o == 8 && empty_o && ready_o && !ovf_o, "R1", free_o, 8);
    chk(irq_o == 0, "R1 irq off", irq_o, 0);
    tx_en_i = 1; #1;
    chk(irq_o == 1, "R1 irq on enable", irq_o, 1);

    // R4 R5 R2 R6 vector walk
    foreach (VEC[i]) begin
      set_empty(VEC[i][8]);
      lvl_code_i = VEC[i][7:6];
      for (int k = 0; k < int'(VEC[i][5:1]); k++) push(8'(k));
      @(negedge clk_i);
      chk(int'(free_o) == (VEC[i][8] ? 16 : 8) - int'(VEC[i][5:1]), "R2", free_o,
          (VEC[i][8] ? 16 : 8) - int'(VEC[i][5:1]));
      chk(irq_o == VEC[i][0], VEC[i][8] ? "R5" : "R4", irq_o, VEC[i][0]);
      tx_en_i = 0; #1;
      chk(irq_o == 0, "R6 gate", irq_o, 0);
      tx_en_i = 1;
    end

    // R6 code 00: one byte withdraws the request
    set_empty(0); lvl_code_i = 2'b00;
    chk(irq_o == 1, "R6 empty", irq_o, 1);
    push(8'h5A);
    chk(irq_o == 0, "R6 withdraw", irq_o, 0);

    // R3 ordering, R11 flags
    set_empty(0);
    push(8'hA1); push(8'hB2); push(8'hC3);
    chk(!empty_o && ready_o, "R11 partial", empty_o, 0);
    pop_chk(8'hA1, "R3"); pop_chk(8'hB2, "R3"); pop_chk(8'hC3, "R3");
    chk(empty_o && free_o == 8, "R11 empty", free_o, 8);

    // R8 pop on empty
    @(negedge clk_i); rd_en_i = 1;
    @(negedge clk_i); rd_en_i = 0;
    chk(free_o == 8 && empty_o, "R8", free_o, 8);

    // R7 overflow
    for (int k = 0; k < 8; k++) push(8'h20 + 8'(k));
    chk(!ready_o && free_o == 0, "R11 full", ready_o, 0);
    chk(ovf_o == 0, "R7 no pulse on accepted write", ovf_o, 0);
    push(8'hEE);
    chk(ovf_o == 1, "R7 pulse", ovf_o, 1);
    @(negedge clk_i);
    chk(ovf_o == 0, "R7 single cycle", ovf_o, 0);
    for (int k = 0; k < 8; k++) pop_chk(8'h20 + 8'(k), "R7 order");
    chk(empty_o, "R7 dropped byte absent", empty_o, 1);

    // R9 simultaneous, mid fill
    push(8'h01); push(8'h02);
    @(negedge clk_i); wr_en_i = 1; rd_en_i = 1; wr_data_i = 8'h03;
    @(negedge clk_i); wr_en_i = 0; rd_en_i = 0;
    chk(free_o == 6, "R9 count kept", free_o, 6);
    pop_chk(8'h02, "R9"); pop_chk(8'h03, "R9");

    // R9 simultaneous on full
    for (int k = 0; k < 8; k++) push(8'h10 + 8'(k));
    @(negedge clk_i); wr_en_i = 1; rd_en_i = 1; wr_data_i = 8'hAA;
    @(negedge clk_i); wr_en_i = 0; rd_en_i = 0;
    chk(ovf_o == 1, "R9 full ovf", ovf_o, 1);
    chk(free_o == 1, "R9 full pop taken", free_o, 1);
    for (int k = 1; k < 8; k++) pop_chk(8'h10 + 8'(k), "R9 full order");
    chk(empty_o, "R9 write dropped", empty_o, 1);

    // R10 depth change empties, deep capacity 16
    push(8'h77); push(8'h78); push(8'h79);
    @(negedge clk_i); deep_i = 1;
    @(negedge clk_i);
    chk(empty_o && free_o == 16, "R10", free_o, 16);
    for (int k = 0; k < 16; k++) push(8'h40 + 8'(k));
    chk(free_o == 0 && !ready_o, "R2 deep full", free_o, 0);
    pop_chk(8'h40, "R3 deep");
    // R10 write in change cycle discarded
    @(negedge clk_i); deep_i = 0; wr_en_i = 1; wr_data_i = 8'h99;
    @(negedge clk_i); wr_en_i = 0;
    chk(empty_o && free_o == 8, "R10 write discarded", free_o, 8);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule